// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns three serial audio input lines into six parallel signed samples. It is a slave: an external bit clock and an external word clock (or frame sync) come in on pins. The block oversamples them with its own system clock, which must run at least eight times faster than the bit clock. A three-bit format field picks one of six framing conventions. Four are stereo formats that use all three lines: two-channel I2S, left-justified, right-justified, and a DSP style that marks each word with a frame-sync pulse. The other two are single-line packed formats that carry all six channels: one with 256 bit clocks per frame and one with 128. A two-bit field sets the word length to 16, 20 or 24 bits.

Every received word is two's complement and arrives MSB first. It is stored left-aligned in a 24-bit register, and the unused low bits read as zero. The six results are updated together and announced by a one-cycle strobe after the last right-channel word of each frame. The sample outputs hold their values between strobes.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, all six sample outputs are zero and the strobe is low until a frame has been received.
- R2: In format 000 (I2S), the word clock is low for left and high for right. The MSB is sampled on the second rising bit-clock edge after a word-clock change. One frame is 64 bit clocks.
- R3: In format 011 (left-justified), the word clock is high for left. The MSB is sampled on the first rising bit-clock edge after the word-clock change.
- R4: In format 001 (right-justified), the word clock is high for left and each half-frame is 32 bit clocks. The LSB is sampled on the last rising edge before the next word-clock change, so an N-bit word starts 32-N edges into the half.
- R5: In format 010 (DSP), data is sampled on falling bit-clock edges. A frame-sync rise seen at a falling edge starts a word, and its MSB is taken on the next falling edge. Words go alternately to left and right, and the first word after reset is left.
- R6: In format 100 (packed, 256 clocks), sdin bit 0 carries eight 32-clock slots sampled on rising edges. The first group of four slots has the word clock low and holds left channels 0, 2, 4 and then a blank slot. The second group has the word clock high and holds right channels 1, 3, 5 and then a blank slot. Each word starts one clock after its slot begins.
- R7: In format 101 (packed, 128 clocks), each group is three 20-clock slots followed by a 4-clock gap. The word clock is high for the left group. Each word starts at the first clock of its slot. Word length is capped at 20, so code 00 is received as 20 bits.
- R8: Word-length code 00 means 24 bits, 01 means 20 and 10 means 16. Code 11 is received as 24 bits. Shorter words are stored in the top bits with zero fill below.
- R9: The strobe is high for exactly one clock cycle per frame. It comes after the last bit of the last right-channel word, and all six outputs change in that same cycle and at no other time.
- R10: In formats 110 and 111 nothing is captured. The strobe stays low and the outputs keep their values.
- R11: Channel mapping. In the stereo and DSP formats, line l feeds channel 2l (left) and channel 2l+1 (right). In the packed formats, slot s of a group feeds channel 2s (left group) or channel 2s+1 (right group).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_i | input | 3 | Framing format code |
| wlen_i | input | 2 | Word-length code |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word clock or frame sync |
| sdin_i | input | 3 | Serial data lines, bit l is line l |
| smp_o | output | 6 x 24 | Received samples, element c is channel c, left-aligned |
| smp_valid_o | output | 1 | One-cycle strobe when a full frame has been updated |

## Verification
A bit-clock edge driven onto the pins is sampled through SYNC_STAGES synchronizer flops. It is then seen as an event one cycle later and written into the working registers. It is copied to the outputs on the next cycle, so the strobe and the new samples are due exactly SYNC_STAGES+2 system clocks after the edge that carries the final bit of a frame. The bench records that due cycle together with a snapshot of the frame's expected samples at the moment it drives that edge. Once per system clock, on the falling edge, it compares the strobe and all six outputs against a model that applies the snapshot only in the due cycle. Any early, late, missing or extra strobe therefore fails in the exact cycle it occurs.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int unsigned SMP_W       = 24;
  localparam int unsigned N_LINE      = 3;
  localparam int unsigned N_CH        = 2 * N_LINE;
  localparam int unsigned KIDX_W      = $clog2(SMP_W);
  localparam int unsigned OFF_W       = 6;
  localparam int unsigned STEREO_HALF = 32;
  localparam int unsigned PK256_SLOT  = 32;
  localparam int unsigned PK128_SLOT  = 20;
  localparam int unsigned PK_WORDS    = 3;
  localparam int unsigned PK128_MAX   = 20;

  typedef enum logic [2:0] {
    FMT_I2S   = 3'b000,
    FMT_RJ    = 3'b001,
    FMT_DSP   = 3'b010,
    FMT_LJ    = 3'b011,
    FMT_PK256 = 3'b100,
    FMT_PK128 = 3'b101,
    FMT_AUX   = 3'b110,
    FMT_RSV   = 3'b111
  } fmt_e;

  function automatic logic [KIDX_W-1:0] word_len(input logic [1:0] code, input fmt_e f);
    logic [KIDX_W-1:0] n;
    case (code)
      2'b01:   n = KIDX_W'(20);
      2'b10:   n = KIDX_W'(16);
      default: n = KIDX_W'(SMP_W);
    endcase
    if (f == FMT_PK128 && n > KIDX_W'(PK128_MAX)) n = KIDX_W'(PK128_MAX);
    return n;
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= in_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign out_o = stg_q[STAGES-1];

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              bclk_s_i,
  input  logic              wclk_s_i,
  output logic              cap_o,
  output logic              side_o,
  output logic [1:0]        slot_o,
  output logic [KIDX_W-1:0] kidx_o,
  output logic              last_o,
  output logic              packed_o
);

  // registered state
  logic             b_q, wp_q, primed_q, lock_q, dside_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       slot_q;
  // next state
  logic             wp_d, primed_d, lock_d, dside_d;
  logic [OFF_W-1:0] off_d;
  logic [1:0]       slot_d;

  // decoded format
  logic              is_dsp, active, left_lvl;
  logic [KIDX_W-1:0] len;
  logic [OFF_W-1:0]  pitch, start;

  always_comb begin
    is_dsp   = (fmt_i == FMT_DSP);
    packed_o = (fmt_i == FMT_PK256) || (fmt_i == FMT_PK128);
    active   = (fmt_i != FMT_AUX) && (fmt_i != FMT_RSV);
    len      = word_len(wlen_i, fmt_i);
    pitch    = (fmt_i == FMT_PK128) ? OFF_W'(PK128_SLOT) : OFF_W'(PK256_SLOT);
    left_lvl = 1'b1;
    start    = '0;
    case (fmt_i)
      FMT_I2S:   begin start = OFF_W'(1); left_lvl = 1'b0; end
      FMT_RJ:    start = OFF_W'(STEREO_HALF) - OFF_W'(len);
      FMT_DSP:   start = OFF_W'(1);
      FMT_PK256: begin start = OFF_W'(1); left_lvl = 1'b0; end
      default:   start = '0;
    endcase
  end

  // event and position of the current bit-clock sample point
  logic             ev, bnd, lock_cur, side_cur, wrap, in_range, slot_ok;
  logic [OFF_W-1:0] off_cur, rel;
  logic [1:0]       slot_cur;

  always_comb begin
    ev       = is_dsp ? (b_q & ~bclk_s_i) : (~b_q & bclk_s_i);
    bnd      = ev & primed_q & (is_dsp ? (wclk_s_i & ~wp_q) : (wclk_s_i ^ wp_q));
    wrap     = (off_q == pitch - OFF_W'(1));
    off_cur  = bnd ? '0 : (wrap ? '0 : off_q + OFF_W'(1));
    slot_cur = bnd ? 2'd0 : ((wrap && slot_q != 2'd3) ? slot_q + 2'd1 : slot_q);
    lock_cur = lock_q | bnd;
    side_cur = is_dsp ? (bnd ? ~dside_q : dside_q) : (wclk_s_i != left_lvl);
    rel      = off_cur - start;
    in_range = (off_cur >= start) && (rel < OFF_W'(len));
    slot_ok  = packed_o ? (slot_cur < 2'(PK_WORDS)) : (slot_cur == 2'd0);
    cap_o    = ev & active & lock_cur & in_range & slot_ok;
    side_o   = side_cur;
    slot_o   = slot_cur;
    kidx_o   = rel[KIDX_W-1:0];
    last_o   = cap_o & side_cur & (rel == OFF_W'(len) - OFF_W'(1)) &
               (~packed_o | (slot_cur == 2'(PK_WORDS - 1)));
  end

  always_comb begin
    wp_d     = wp_q;
    primed_d = primed_q;
    lock_d   = lock_q;
    off_d    = off_q;
    slot_d   = slot_q;
    dside_d  = dside_q;
    if (ev) begin
      wp_d     = wclk_s_i;
      primed_d = 1'b1;
      lock_d   = lock_cur;
      off_d    = off_cur;
      slot_d   = slot_cur;
      if (is_dsp && bnd) dside_d = side_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q      <= 1'b0;
      wp_q     <= 1'b0;
      primed_q <= 1'b0;
      lock_q   <= 1'b0;
      off_q    <= '0;
      slot_q   <= '0;
      dside_q  <= 1'b1;
    end else begin
      b_q      <= bclk_s_i;
      wp_q     <= wp_d;
      primed_q <= primed_d;
      lock_q   <= lock_d;
      off_q    <= off_d;
      slot_q   <= slot_d;
      dside_q  <= dside_d;
    end
  end

  // R5: every DSP word start flips the left/right assignment
  p_dsp_alt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dsp && bnd) |=> (dside_q != $past(dside_q)));

  // R7: the 128-clock packed format never stores beyond bit 20 of a word
  p_p128_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i == FMT_PK128 && cap_o) |-> (kidx_o < KIDX_W'(PK128_MAX)));

endmodule

// File: rtl/aud_rx_store.sv
module aud_rx_store
  import aud_rx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap_i,
  input  logic                         side_i,
  input  logic [1:0]                   slot_i,
  input  logic [KIDX_W-1:0]            kidx_i,
  input  logic                         last_i,
  input  logic                         packed_i,
  input  logic [N_LINE-1:0]            sd_i,
  output logic [N_CH-1:0][SMP_W-1:0]   smp_o,
  output logic                         valid_o
);

  logic [N_CH-1:0] wr_en;
  logic            fe_q, valid_q;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned GRP  = ch / 2;
    localparam logic        SIDE = 1'(ch % 2);

    logic             bit_in;
    logic [SMP_W-1:0] work_q, work_d, out_q;

    always_comb begin
      wr_en[ch] = cap_i && (side_i == SIDE) && (!packed_i || slot_i == 2'(GRP));
      bit_in    = packed_i ? sd_i[0] : sd_i[GRP];
      work_d    = work_q;
      if (wr_en[ch]) begin
        if (kidx_i == '0) work_d = '0;
        work_d[KIDX_W'(SMP_W - 1) - kidx_i] = bit_in;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_q <= '0;
        out_q  <= '0;
      end else begin
        work_q <= work_d;
        if (fe_q) out_q <= work_q;
      end
    end

    assign smp_o[ch] = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      fe_q    <= last_i;
      valid_q <= fe_q;
    end
  end

  assign valid_o = valid_q;

  // R11: a single packed line writes at most one channel per bit
  p_onehot_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    packed_i |-> $onehot0(wr_en));

  // R9: the strobe lasts one cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R9: outputs move only together with the strobe
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(smp_o));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 fmt_i,
  input  logic [1:0]                 wlen_i,
  input  logic                       bclk_i,
  input  logic                       wclk_i,
  input  logic [N_LINE-1:0]          sdin_i,
  output logic [N_CH-1:0][SMP_W-1:0] smp_o,
  output logic                       smp_valid_o
);

  localparam int unsigned PIN_W = N_LINE + 2;

  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  logic [PIN_W-1:0]  pins_s;
  logic              cap, side, last, pk;
  logic [1:0]        slot;
  logic [KIDX_W-1:0] kidx;
  fmt_e              fmt;

  assign fmt = fmt_e'(fmt_i);

  aud_rx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .in_i  ({bclk_i, wclk_i, sdin_i}),
    .out_o (pins_s)
  );

  aud_rx_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fmt_i    (fmt),
    .wlen_i   (wlen_i),
    .bclk_s_i (pins_s[PIN_W-1]),
    .wclk_s_i (pins_s[PIN_W-2]),
    .cap_o    (cap),
    .side_o   (side),
    .slot_o   (slot),
    .kidx_o   (kidx),
    .last_o   (last),
    .packed_o (pk)
  );

  aud_rx_store u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_i    (cap),
    .side_i   (side),
    .slot_i   (slot),
    .kidx_i   (kidx),
    .last_i   (last),
    .packed_i (pk),
    .sd_i     (pins_s[N_LINE-1:0]),
    .smp_o    (smp_o),
    .valid_o  (smp_valid_o)
  );

  // R10: three cycles in an inactive format leave the strobe low
  p_aux_quiet_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fmt_i[2:1] == 2'b11 && $past(fmt_i[2:1]) == 2'b11 && $past(fmt_i[2:1], 2) == 2'b11)
      |-> !smp_valid_o);

endmodule

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_B     = 6;
  localparam int SYNC       = 2;
  localparam int LAT        = SYNC + 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2:0]          fmt_i = 3'b000;
  logic [1:0]          wlen_i = 2'b00;
  logic                bclk_i = 1'b0;
  logic                wclk_i = 1'b0;
  logic [2:0]          sdin_i = 3'b000;
  logic [5:0][23:0]    smp_o;
  logic                smp_valid_o;

  aud_serial_rx #(.SYNC_STAGES(SYNC)) u_aud_serial_rx (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .wlen_i(wlen_i),
    .bclk_i(bclk_i), .wclk_i(wclk_i), .sdin_i(sdin_i),
    .smp_o(smp_o), .smp_valid_o(smp_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, errors = 0, cyc = 0, due = -1;
  bit    mon_on = 1'b0, done = 1'b0;
  string cur_req = "R1";
  logic [23:0] exp_smp [6];
  logic [23:0] pend    [6];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // cycle-by-cycle comparison against the countdown model
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      bit ev_now;
      ev_now = (cyc == due);
      if (ev_now) for (int c = 0; c < 6; c++) exp_smp[c] = pend[c];
      checks++;
      if (smp_valid_o !== ev_now) begin
        errors++;
        $display("FAIL %s R9 strobe cycle %0d actual %0b expected %0b", cur_req, cyc, smp_valid_o, ev_now);
      end
      for (int c = 0; c < 6; c++) begin
        if (smp_o[c] !== exp_smp[c]) begin
          errors++;
          $display("FAIL %s ch%0d cycle %0d actual %06h expected %06h", cur_req, c, cyc, smp_o[c], exp_smp[c]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog %s actual hung expected finish", cur_req);
    report();
  end

  function automatic int len_of(input logic [2:0] f, input logic [1:0] c);
    int n;
    n = (c == 2'b01) ? 20 : (c == 2'b10) ? 16 : 24;
    if (f == 3'b101 && n > 20) n = 20;
    return n;
  endfunction

  function automatic logic [23:0] align(input logic [23:0] v, input int n);
    return v & (24'hFFFFFF << (24 - n));
  endfunction

  task automatic drive_pos(input bit rise_smp, input logic w, input logic [2:0] d,
                           input bit last, input logic [23:0] fr [6]);
    @(negedge clk);
    bclk_i = rise_smp ? 1'b0 : 1'b1; wclk_i = w; sdin_i = d;
    repeat (HALF_B - 1) @(negedge clk);
    @(negedge clk);
    bclk_i = ~bclk_i;
    if (last) begin
      due = cyc + LAT;
      for (int c = 0; c < 6; c++) pend[c] = fr[c];
    end
    repeat (HALF_B - 1) @(negedge clk);
  endtask

  task automatic idle(input logic [2:0] lay, input int cnt);
    logic [23:0] z [6];
    logic w;
    for (int c = 0; c < 6; c++) z[c] = '0;
    w = (lay == 3'b000 || lay == 3'b100) ? 1'b1 : 1'b0;
    for (int i = 0; i < cnt; i++) drive_pos(lay != 3'b010, w, 3'b000, 1'b0, z);
  endtask

  // builds one frame in layout lay, from the requirement text
  task automatic send_frame(input logic [2:0] lay, input int n, input logic [23:0] fr [6], input bit expect_on);
    int total;
    total = (lay == 3'b100) ? 256 : (lay == 3'b101) ? 128 : 64;
    for (int i = 0; i < total; i++) begin
      logic w; logic [2:0] d; bit last; int h, p, s, k, sl;
      d = 3'b000; last = 1'b0;
      case (lay)
        3'b100: begin
          h = i / 128; p = i % 128; sl = p / 32; k = (p % 32) - 1; w = h[0];
          if (sl < 3 && k >= 0 && k < n) begin
            d[0] = fr[2*sl+h][23-k]; last = (h == 1 && sl == 2 && k == n - 1);
          end
        end
        3'b101: begin
          h = i / 64; p = i % 64; sl = p / 20; k = p % 20; w = ~h[0];
          if (p < 60 && k < n) begin
            d[0] = fr[2*sl+h][23-k]; last = (h == 1 && sl == 2 && k == n - 1);
          end
        end
        default: begin
          h = i / 32; p = i % 32;
          if (lay == 3'b010) begin s = 1; w = (p < 2); end
          else if (lay == 3'b000) begin s = 1; w = h[0]; end
          else if (lay == 3'b011) begin s = 0; w = ~h[0]; end
          else begin s = 32 - n; w = ~h[0]; end
          k = p - s;
          if (k >= 0 && k < n) begin
            for (int l = 0; l < 3; l++) d[l] = fr[2*l+h][23-k];
            last = (h == 1 && k == n - 1);
          end
        end
      endcase
      drive_pos(lay != 3'b010, w, d, last && expect_on, fr);
    end
  endtask

  task automatic do_reset(input logic [2:0] f, input logic [1:0] c);
    @(negedge clk);
    rst_n = 1'b0; due = -1;
    for (int k = 0; k < 6; k++) exp_smp[k] = '0;
    fmt_i = f; wlen_i = c; bclk_i = (f == 3'b010); wclk_i = 1'b0; sdin_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input string req, input logic [2:0] f, input logic [1:0] c,
                     input int frames, input bit special);
    logic [23:0] fr [6];
    int n;
    cur_req = req;
    n = len_of(f, c);
    do_reset(f, c);
    idle(f, 4);
    for (int j = 0; j < frames; j++) begin
      for (int k = 0; k < 6; k++) begin
        if (special && j == 1) fr[k] = align((k % 2) ? 24'h7FFFFF : 24'h800000, n);
        else fr[k] = align(24'($urandom()) ^ 24'(k * 24'h111111), n);
      end
      send_frame(f, n, fr, 1'b1);
    end
    idle(f, 6);
  endtask

  initial begin
    logic [23:0] fr [6];
    for (int k = 0; k < 6; k++) begin exp_smp[k] = '0; pend[k] = '0; end
    // R1: reset state
    repeat (4) @(negedge clk);
    checks++;
    if (smp_valid_o !== 1'b0 || smp_o !== '0) begin
      errors++;
      $display("FAIL R1 reset actual %0b/%h expected 0/0", smp_valid_o, smp_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    run("R2 R11 R9 I2S 24b",   3'b000, 2'b00, 2, 1'b1);
    run("R3 R8 LJ 20b",        3'b011, 2'b01, 2, 1'b1);
    run("R4 R8 RJ 16b",        3'b001, 2'b10, 2, 1'b0);
    run("R4 RJ 24b",           3'b001, 2'b00, 1, 1'b0);
    run("R5 R11 DSP 24b",      3'b010, 2'b00, 3, 1'b1);
    run("R6 R11 PK256 24b",    3'b100, 2'b00, 2, 1'b1);
    run("R6 R8 PK256 16b",     3'b100, 2'b10, 1, 1'b0);
    run("R7 PK128 code00",     3'b101, 2'b00, 2, 1'b1);
    run("R7 R8 PK128 16b",     3'b101, 2'b10, 1, 1'b0);
    run("R8 I2S code11",       3'b000, 2'b11, 2, 1'b0);

    // R10: inactive formats capture nothing, outputs hold
    cur_req = "R10 format 110";
    for (int k = 0; k < 6; k++) fr[k] = 24'hA5A5A5 ^ 24'(k);
    @(negedge clk); fmt_i = 3'b110;
    send_frame(3'b000, 24, fr, 1'b0);
    cur_req = "R10 format 111";
    @(negedge clk); fmt_i = 3'b111;
    send_frame(3'b000, 24, fr, 1'b0);
    idle(3'b000, 4);

    report();
  end

endmodule